// File: doc/BRIEF.md
# Snoop-Qualified Address Parity Unit

This block protects a 32-bit address bus with one odd-parity bit per address byte. While the local agent owns the bus and starts a transfer, the unit computes the four parity bits and drives them out with an output-enable. A wrapper uses that enable to tri-state the pins.

When another agent owns the bus, the unit watches for a snoop cycle. A snoop cycle is one where transfer-start and global are both high in the same cycle. On that cycle it captures the incoming address and parity and compares them one clock later.

A mismatch counts only when the parity-check enable was set. It then produces a one-cycle error pulse. The machine-check enable decides the result. If it is set, the error raises a one-cycle machine-check request. If it is clear, the error sets a sticky checkstop flag, which only reset clears. The bus has no streaming data path. Every pin is a plain per-cycle control or status signal, so no valid/ready handshake and no back-pressure apply.

Top module: `apar_unit`

## Requirements
- R1: Parity output bit k covers address byte k counted from the most significant end. Bit 0 covers addr[31:24] and bit 3 covers addr[7:0]. Each bit makes its byte plus itself hold an odd number of ones.
- R2: par_oe is high exactly when bus_owner and xfer_start are both high in that cycle, with no register delay. While par_oe is low, par_out reads 0.
- R3: A parity compare takes place only for a cycle with bus_owner low and both xfer_start and global_snoop high. No other cycle ever raises err_pulse, whatever its parity.
- R4: If chk_en is 0 in the qualifying cycle, a parity mismatch raises no err_pulse, no mchk_req and no checkstop.
- R5: For a qualifying cycle whose captured parity mismatches, with chk_en high, err_pulse is high for the one cycle that follows the capturing clock edge.
- R6: An error with mce_en high in its qualifying cycle raises mchk_req in the same cycle as err_pulse, provided checkstop is not set.
- R7: An error with mce_en low sets checkstop at the next clock edge. Checkstop then stays high until reset.
- R8: While checkstop is high, no mchk_req is raised, even for a later error with mce_en high. err_pulse still reports that error.
- R9: After reset, err_pulse, mchk_req and checkstop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 32 | Address bus value |
| bus_owner | input | 1 | Local agent is address-bus master |
| xfer_start | input | 1 | Transfer start, marks a valid address |
| global_snoop | input | 1 | Transfer is global and must be snooped |
| par_in | input | 4 | Incoming parity bits, same byte order as par_out |
| chk_en | input | 1 | Address parity check enable |
| mce_en | input | 1 | Machine-check enable; when low, errors checkstop |
| par_out | output | 4 | Generated parity bits |
| par_oe | output | 1 | Output-enable for par_out |
| err_pulse | output | 1 | One-cycle parity error indication |
| mchk_req | output | 1 | One-cycle machine-check request |
| checkstop | output | 1 | Sticky fatal-error flag |

## Verification
par_out and par_oe are combinational. The bench checks them a nanosecond after driving inputs, before the next clock edge. err_pulse and mchk_req for a cycle are due just after the edge that captures it, so the bench samples them one nanosecond after that edge. Checkstop lags one more edge. The bench's model therefore compares the flag against its state from before the current error, and only then updates that state.

// File: rtl/apar_pkg.sv
package apar_pkg;
  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_MCHK = 2'd1,
    ROUTE_STOP = 2'd2
  } apar_route_e;
endpackage

// File: rtl/apar_gen.sv
module apar_gen #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = ADDR_W / LANE_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [LANES-1:0]  parity
);
  // lane 0 is the most significant byte
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign parity[g] = ~^addr[ADDR_W-1-g*LANE_W -: LANE_W];
  end
endmodule

// File: rtl/apar_capture.sv
module apar_capture #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qualify,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  par_in,
  input  logic              chk_en,
  input  logic              mce_en,
  output logic              q_vld,
  output logic [ADDR_W-1:0] q_addr,
  output logic [LANES-1:0]  q_par,
  output logic              q_chk,
  output logic              q_mce
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_addr <= '0;
      q_par  <= '0;
      q_chk  <= 1'b0;
      q_mce  <= 1'b0;
    end else begin
      q_vld <= qualify;
      if (qualify) begin
        q_addr <= addr_in;
        q_par  <= par_in;
        q_chk  <= chk_en;
        q_mce  <= mce_en;
      end
    end
  end

  assert_capture_needs_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> $past(qualify));
endmodule

// File: rtl/apar_route.sv
module apar_route
  import apar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic q_vld,
  input  logic q_chk,
  input  logic q_mce,
  input  logic mismatch,
  output logic err_pulse,
  output logic mchk_req,
  output logic checkstop
);
  apar_route_e route;

  always_comb begin
    err_pulse = q_vld && q_chk && mismatch;
    route     = ROUTE_NONE;
    if (err_pulse) route = q_mce ? ROUTE_MCHK : ROUTE_STOP;
    mchk_req  = (route == ROUTE_MCHK) && !checkstop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   checkstop <= 1'b0;
    else if (route == ROUTE_STOP) checkstop <= 1'b1;
  end

  assert_chkstop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    checkstop |=> checkstop);
  assert_chkstop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(checkstop) |-> $past(err_pulse && !q_mce));
  assert_mchk_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |-> (err_pulse && !checkstop));
endmodule

// File: rtl/apar_unit.sv
module apar_unit #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = ADDR_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_owner,
  input  logic              xfer_start,
  input  logic              global_snoop,
  input  logic [LANES-1:0]  par_in,
  input  logic              chk_en,
  input  logic              mce_en,
  output logic [LANES-1:0]  par_out,
  output logic              par_oe,
  output logic              err_pulse,
  output logic              mchk_req,
  output logic              checkstop
);
  logic [LANES-1:0]  gen_par;
  logic [LANES-1:0]  exp_par;
  logic              qualify;
  logic              q_vld, q_chk, q_mce;
  logic [ADDR_W-1:0] q_addr;
  logic [LANES-1:0]  q_par;

  apar_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_gen_out (.addr(addr), .parity(gen_par));

  assign par_oe  = bus_owner && xfer_start;
  assign par_out = par_oe ? gen_par : '0;
  assign qualify = !bus_owner && xfer_start && global_snoop;

  apar_capture #(.ADDR_W(ADDR_W), .LANES(LANES)) i_cap (
    .clk(clk), .rst_n(rst_n), .qualify(qualify), .addr_in(addr), .par_in(par_in),
    .chk_en(chk_en), .mce_en(mce_en), .q_vld(q_vld), .q_addr(q_addr), .q_par(q_par),
    .q_chk(q_chk), .q_mce(q_mce));

  apar_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_gen_chk (.addr(q_addr), .parity(exp_par));

  apar_route i_route (
    .clk(clk), .rst_n(rst_n), .q_vld(q_vld), .q_chk(q_chk), .q_mce(q_mce),
    .mismatch(|(exp_par ^ q_par)), .err_pulse(err_pulse), .mchk_req(mchk_req),
    .checkstop(checkstop));

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !par_oe |-> (par_out == '0));
  assert_err_after_snoop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(!bus_owner && xfer_start && global_snoop));
  assert_err_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(chk_en));
  assert_mchk_needs_mce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req |-> $past(mce_en));
endmodule

// File: tb/test_apar_unit.sv
`timescale 1ns/1ps
module test_apar_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic bus_owner = 1'b0, xfer_start = 1'b0, global_snoop = 1'b0;
  logic [3:0] par_in = '0;
  logic chk_en = 1'b0, mce_en = 1'b0;
  logic [3:0] par_out;
  logic par_oe, err_pulse, mchk_req, checkstop;

  int checks = 0;
  int errors = 0;
  bit exp_stop = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  apar_unit i_apar_unit (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bus_owner(bus_owner), .xfer_start(xfer_start),
    .global_snoop(global_snoop), .par_in(par_in), .chk_en(chk_en), .mce_en(mce_en),
    .par_out(par_out), .par_oe(par_oe), .err_pulse(err_pulse), .mchk_req(mchk_req),
    .checkstop(checkstop));

  function automatic logic [3:0] ref_par(input logic [31:0] a);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = a >> (8 * (3 - k));
      p[k] = ($countones(b) % 2) == 0;
    end
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_owner = 0; xfer_start = 0; global_snoop = 0;
    repeat (2) @(negedge clk);
    check(!err_pulse && !mchk_req && !checkstop, "R9", {err_pulse, mchk_req, checkstop}, 0);
    rst_n = 1'b1;
    exp_stop = 1'b0;
  endtask

  // one bus cycle: drive, check combinational outputs, then sequenced outputs
  task automatic cycle(input logic [31:0] a, input bit own, input bit ts, input bit gb,
                       input logic [3:0] pi, input bit ce, input bit me);
    bit qual, exp_err, exp_mchk;
    logic [3:0] exp_out;
    @(negedge clk);
    addr = a; bus_owner = own; xfer_start = ts; global_snoop = gb;
    par_in = pi; chk_en = ce; mce_en = me;
    #1;
    exp_out = (own && ts) ? ref_par(a) : 4'h0;
    check(par_oe == (own && ts), "R2", par_oe, own && ts);
    check(par_out == exp_out, "R1", par_out, exp_out);
    qual = !own && ts && gb;
    exp_err = qual && ce && (pi != ref_par(a));
    exp_mchk = exp_err && me && !exp_stop;
    @(posedge clk);
    #1;
    check(err_pulse == exp_err, exp_err ? "R5" : (qual ? "R4" : "R3"), err_pulse, exp_err);
    check(mchk_req == exp_mchk, exp_stop ? "R8" : "R6", mchk_req, exp_mchk);
    check(checkstop == exp_stop, "R7", checkstop, exp_stop);
    if (exp_err && !me) exp_stop = 1'b1;
  endtask

  task automatic idle();
    cycle(32'h0, 0, 0, 0, 4'h0, 0, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: owner drives known patterns
    cycle(32'h0000_0000, 1, 1, 0, 4'h0, 1, 1);
    cycle(32'hFF01_0380, 1, 1, 1, 4'h0, 1, 1);
    // R3: master cycle with bad parity, global without start
    cycle(32'h1234_5678, 1, 1, 1, 4'hF ^ ref_par(32'h1234_5678), 1, 1);
    cycle(32'h1234_5678, 0, 0, 1, 4'hF ^ ref_par(32'h1234_5678), 1, 1);
    cycle(32'h1234_5678, 0, 1, 0, 4'hF ^ ref_par(32'h1234_5678), 1, 1);
    // R4: check disabled
    cycle(32'hA5A5_0001, 0, 1, 1, ~ref_par(32'hA5A5_0001), 0, 0);
    idle();
    check(checkstop == 1'b0, "R4", checkstop, 0);
    // good snoop, then R5/R6 bad snoop with mce
    cycle(32'hDEAD_BEEF, 0, 1, 1, ref_par(32'hDEAD_BEEF), 1, 1);
    cycle(32'hDEAD_BEEF, 0, 1, 1, ref_par(32'hDEAD_BEEF) ^ 4'h8, 1, 1);
    idle();
    check(err_pulse == 1'b0, "R5", err_pulse, 0);
    // R7: checkstop
    cycle(32'h0F0F_F0F0, 0, 1, 1, ref_par(32'h0F0F_F0F0) ^ 4'h1, 1, 0);
    idle();
    idle();
    // R8: later error with mce blocked
    cycle(32'h8000_0001, 0, 1, 1, ref_par(32'h8000_0001) ^ 4'h2, 1, 1);
    idle();
    // random phase
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [3:0] p;
      a = $urandom;
      p = ($urandom % 3 == 0) ? 4'($urandom) : ref_par(a);
      cycle(a, ($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 3) != 0, p,
            ($urandom % 5) != 0, ($urandom % 20) != 0);
    end
    do_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule